// File: doc/BRIEF.md
# Timer Channel Clock Gating and Trigger Control

This block decides, for one channel of a 16-bit timer/counter, when the counter advances on a tick of the already selected counter clock. Two independent state bits gate that tick. The first is an enable bit, which only the control-register commands set. The control-register commands and a mode-dependent disable event clear it. The second is a run bit, which triggers set and a mode-dependent stop event clears. A tick reaches the counter only when both bits are set.

A mode bit selects capture operation (0) or waveform operation (1). In capture mode, a register-B load event may disable or stop the channel. In waveform mode, a register-C compare event may disable or stop it, and may also act as a trigger. Each of these options is controlled by its own option bit. Any trigger clears the counter in the cycle it arrives. The block also holds the counter itself, so that the effect of gating and triggering can be seen at the ports. Capture register loading and waveform output shaping belong to neighbouring logic.

Top module: `tcg_channel`

## Requirements
- R1: While `rst_n` is low at a clock edge, the enable bit, the run bit and the counter all clear. After reset, `clk_sta_o`, `cnt_en_o` and `count_o` read 0.
- R2: `cmd_en_i` sets the enable bit at the next edge and `cmd_dis_i` clears it. `clk_sta_o` shows the enable bit. If both commands arrive in the same cycle, the bit ends up clear.
- R3: `cnt_en_o` is 1 exactly when `tick_i`, the enable bit and the run bit are all 1. The counter advances only in such cycles.
- R4: A trigger drives `cnt_clr_o` high in the same cycle and makes `count_o` read 0 after the edge. A trigger is any of `trig_sw_i`, `trig_sync_i` or `trig_ext_i`, or `evt_c_i` when `mode_wave_i`=1 and `opt_c_trg_i`=1. If the enable bit is set, the trigger also sets the run bit.
- R5: While the enable bit is clear, triggers and stop events leave the run bit unchanged. Re-enabling the channel therefore resumes whatever run state it held before.
- R6: In capture mode (`mode_wave_i`=0), `evt_b_i` with `opt_b_dis_i`=1 clears the enable bit.
- R7: In waveform mode (`mode_wave_i`=1), `evt_c_i` with `opt_c_dis_i`=1 clears the enable bit.
- R8: `evt_b_i` clears the run bit when in capture mode with `opt_b_stop_i`=1. `evt_c_i` clears the run bit when in waveform mode with `opt_c_stop_i`=1.
- R9: Register-B options have no effect in waveform mode. Register-C options, including the compare trigger, have no effect in capture mode.
- R10: When a trigger and a stop event arrive in the same cycle, the run bit ends up set.
- R11: The counter is 16 bits wide. It steps by one per gated tick, wraps from 0xFFFF to 0, and the first gated tick after a trigger yields 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Selected counter clock tick |
| cmd_en_i | input | 1 | Enable command strobe |
| cmd_dis_i | input | 1 | Disable command strobe |
| trig_sw_i | input | 1 | Software trigger strobe |
| trig_sync_i | input | 1 | Synchronous (multi-channel) trigger strobe |
| trig_ext_i | input | 1 | External trigger strobe |
| mode_wave_i | input | 1 | 1 = waveform mode, 0 = capture mode |
| opt_b_dis_i | input | 1 | Register-B load disables channel (capture) |
| opt_b_stop_i | input | 1 | Register-B load stops channel (capture) |
| opt_c_dis_i | input | 1 | Register-C compare disables channel (waveform) |
| opt_c_stop_i | input | 1 | Register-C compare stops channel (waveform) |
| opt_c_trg_i | input | 1 | Register-C compare acts as trigger (waveform) |
| evt_b_i | input | 1 | Register-B load event |
| evt_c_i | input | 1 | Register-C compare event |
| cnt_en_o | output | 1 | Gated count enable |
| cnt_clr_o | output | 1 | Counter reset pulse (trigger seen) |
| clk_sta_o | output | 1 | Clock status: enable bit |
| count_o | output | 16 | Counter value |

## Verification
The hardest state to observe is the run bit while the channel is disabled, because no port shows it directly. To reach it, the stimulus first gets the channel counting, then disables it with a register-B load and applies a stop event. Separately, it applies a trigger to a channel that was never started. In each case the channel is then re-enabled, and the stimulus checks whether ticks move the counter. The wrap from 0xFFFF is reached by holding the tick high for a full counter period after a trigger.

// File: rtl/tcg_pkg.sv
// Shared types for the timer channel clock gating block.
package tcg_pkg;
    // Mode and option bits as seen by the decoder.
    typedef struct packed {
        logic wave;
        logic b_dis;
        logic b_stop;
        logic c_dis;
        logic c_stop;
        logic c_trg;
    } tcg_mode_t;

    // Decoded actions on the two gate bits.
    typedef struct packed {
        logic set_en;
        logic clr_en;
        logic start;
        logic stop;
    } tcg_ctl_t;
endpackage

// File: rtl/tcg_event_decode.sv
// Turns commands, triggers and mode-qualified events into latch actions.
// Assumes all strobes are single-cycle and synchronous to clk.
module tcg_event_decode
    import tcg_pkg::*;
(
    input  tcg_mode_t mode_i,
    input  logic      cmd_en_i,
    input  logic      cmd_dis_i,
    input  logic      trig_sw_i,
    input  logic      trig_sync_i,
    input  logic      trig_ext_i,
    input  logic      evt_b_i,
    input  logic      evt_c_i,
    output tcg_ctl_t  ctl_o
);
    logic b_live;
    logic c_live;

    // Qualify each event by the mode it belongs to.
    always_comb begin
        b_live = evt_b_i && !mode_i.wave;
        c_live = evt_c_i && mode_i.wave;
    end

    // Build the action set from commands and qualified events.
    always_comb begin
        ctl_o.set_en = cmd_en_i;
        ctl_o.clr_en = cmd_dis_i || (b_live && mode_i.b_dis) || (c_live && mode_i.c_dis);
        ctl_o.start  = trig_sw_i || trig_sync_i || trig_ext_i || (c_live && mode_i.c_trg);
        ctl_o.stop   = (b_live && mode_i.b_stop) || (c_live && mode_i.c_stop);
    end
endmodule

// File: rtl/tcg_gate_latch.sv
// Holds the enable bit and the run bit that gate the counter clock.
// Clear beats set on the enable bit; start beats stop on the run bit;
// the run bit is frozen while the enable bit is clear.
module tcg_gate_latch
    import tcg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  tcg_ctl_t ctl_i,
    output logic     en_o,
    output logic     run_o
);
    logic en_q;
    logic run_q;

    // Enable bit: commands and disable events, clear has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)            en_q <= 1'b0;
        else if (ctl_i.clr_en) en_q <= 1'b0;
        else if (ctl_i.set_en) en_q <= 1'b1;
    end

    // Run bit: triggers start, events stop, only while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                    run_q <= 1'b0;
        else if (en_q && ctl_i.start)  run_q <= 1'b1;
        else if (en_q && ctl_i.stop)   run_q <= 1'b0;
    end

    assign en_o  = en_q;
    assign run_o = run_q;
endmodule

// File: rtl/tcg_counter.sv
// Up-counter that clears on a trigger and steps on each gated tick.
// Assumes clr_i and step_i are synchronous; clear has priority.
module tcg_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Count register with natural wrap at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr_i)  cnt_q <= '0;
        else if (step_i) cnt_q <= cnt_q + ONE;
    end

    assign count_o = cnt_q;
endmodule

// File: rtl/tcg_channel.sv
// Top of the timer channel clock gating block: decodes commands and
// events, keeps the enable and run bits, and gates ticks into the counter.
// Assumes tick_i is already the selected counter clock, one cycle wide.
module tcg_channel
    import tcg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             cmd_en_i,
    input  logic             cmd_dis_i,
    input  logic             trig_sw_i,
    input  logic             trig_sync_i,
    input  logic             trig_ext_i,
    input  logic             mode_wave_i,
    input  logic             opt_b_dis_i,
    input  logic             opt_b_stop_i,
    input  logic             opt_c_dis_i,
    input  logic             opt_c_stop_i,
    input  logic             opt_c_trg_i,
    input  logic             evt_b_i,
    input  logic             evt_c_i,
    output logic             cnt_en_o,
    output logic             cnt_clr_o,
    output logic             clk_sta_o,
    output logic [CNT_W-1:0] count_o
);
    tcg_mode_t mode;
    tcg_ctl_t  ctl;
    logic      en;
    logic      run;
    logic      gated;

    // Pack the mode inputs for the decoder.
    always_comb begin
        mode.wave   = mode_wave_i;
        mode.b_dis  = opt_b_dis_i;
        mode.b_stop = opt_b_stop_i;
        mode.c_dis  = opt_c_dis_i;
        mode.c_stop = opt_c_stop_i;
        mode.c_trg  = opt_c_trg_i;
    end

    tcg_event_decode u_dec (
        .mode_i      (mode),
        .cmd_en_i    (cmd_en_i),
        .cmd_dis_i   (cmd_dis_i),
        .trig_sw_i   (trig_sw_i),
        .trig_sync_i (trig_sync_i),
        .trig_ext_i  (trig_ext_i),
        .evt_b_i     (evt_b_i),
        .evt_c_i     (evt_c_i),
        .ctl_o       (ctl)
    );

    tcg_gate_latch u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl_i (ctl),
        .en_o  (en),
        .run_o (run)
    );

    // A tick passes only when both gate bits are set.
    always_comb gated = tick_i && en && run;

    tcg_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (ctl.start),
        .step_i  (gated),
        .count_o (count_o)
    );

    assign cnt_en_o  = gated;
    assign cnt_clr_o = ctl.start;
    assign clk_sta_o = en;
endmodule

// File: rtl/tcg_channel_chk.sv
// Assertion checker for tcg_channel, attached by bind.
module tcg_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic             cmd_en_i,
    input logic             cmd_dis_i,
    input logic             trig_sw_i,
    input logic             trig_sync_i,
    input logic             trig_ext_i,
    input logic             mode_wave_i,
    input logic             opt_b_dis_i,
    input logic             opt_b_stop_i,
    input logic             opt_c_dis_i,
    input logic             opt_c_stop_i,
    input logic             opt_c_trg_i,
    input logic             evt_b_i,
    input logic             evt_c_i,
    input logic             cnt_en_o,
    input logic             cnt_clr_o,
    input logic             clk_sta_o,
    input logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R1
    reset_state_chk: assert property (@(posedge clk) !rst_n |=> (!clk_sta_o && count_o == '0));
    // R2
    dis_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_en_i && cmd_dis_i) |=> !clk_sta_o);
    // R3
    gate_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_en_o |-> (tick_i && clk_sta_o));
    // R4
    trig_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_o && !(trig_sw_i || trig_sync_i || trig_ext_i)) |-> (mode_wave_i && evt_c_i && opt_c_trg_i));
    // R4
    clr_then_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_clr_o |=> count_o == '0);
    // R6
    b_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_wave_i && evt_b_i && opt_b_dis_i) |=> !clk_sta_o);
    // R7
    c_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_wave_i && evt_c_i && opt_c_dis_i) |=> !clk_sta_o);
    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en_o && !cnt_clr_o) |=> count_o == $past(count_o) + ONE);
    // R11
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en_o && !cnt_clr_o) |=> $stable(count_o));
endmodule

bind tcg_channel tcg_channel_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/sim_tcg_channel.sv
module sim_tcg_channel;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic cmd_en = 0, cmd_dis = 0, trig_sw = 0, trig_sync = 0, trig_ext = 0;
    logic mode_wave = 0, o_bdis = 0, o_bstop = 0, o_cdis = 0, o_cstop = 0, o_ctrg = 0;
    logic evt_b = 0, evt_c = 0;
    logic cnt_en, cnt_clr, clk_sta;
    logic [15:0] count;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    typedef struct {
        bit          is_state;
        logic        e1;
        logic        e2;
        logic [15:0] ecnt;
        string       tag;
    } item_t;
    item_t q[$];
    event ev;

    always #10 clk = ~clk;

    tcg_channel u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .cmd_en_i(cmd_en), .cmd_dis_i(cmd_dis),
        .trig_sw_i(trig_sw), .trig_sync_i(trig_sync), .trig_ext_i(trig_ext),
        .mode_wave_i(mode_wave), .opt_b_dis_i(o_bdis), .opt_b_stop_i(o_bstop),
        .opt_c_dis_i(o_cdis), .opt_c_stop_i(o_cstop), .opt_c_trg_i(o_ctrg),
        .evt_b_i(evt_b), .evt_c_i(evt_c),
        .cnt_en_o(cnt_en), .cnt_clr_o(cnt_clr), .clk_sta_o(clk_sta), .count_o(count)
    );

    // Monitor: pops expected items and compares them with the ports.
    initial begin
        forever begin
            @(ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                tests++;
                if (!it.is_state) begin
                    if (cnt_en !== it.e1 || cnt_clr !== it.e2) begin
                        fails++;
                        $display("FAIL %s gate/clr act=%b/%b exp=%b/%b", it.tag, cnt_en, cnt_clr, it.e1, it.e2);
                    end
                end else begin
                    if (clk_sta !== it.e1 || count !== it.ecnt) begin
                        fails++;
                        $display("FAIL %s sta/count act=%b/%h exp=%b/%h", it.tag, clk_sta, count, it.e1, it.ecnt);
                    end
                end
            end
        end
    end

    // Driver: inputs already set at negedge; checks comb outputs, then state.
    task automatic cyc(input logic eg, input logic ec, input logic es,
                       input logic [15:0] ecnt, input string tag);
        item_t a;
        item_t b;
        #1;
        a.is_state = 0; a.e1 = eg; a.e2 = ec; a.ecnt = '0; a.tag = tag;
        q.push_back(a);
        -> ev;
        @(posedge clk);
        #1;
        b.is_state = 1; b.e1 = es; b.e2 = 1'b0; b.ecnt = ecnt; b.tag = tag;
        q.push_back(b);
        -> ev;
        cmd_en = 0; cmd_dis = 0; trig_sw = 0; trig_sync = 0; trig_ext = 0;
        o_bdis = 0; o_bstop = 0; o_cdis = 0; o_cstop = 0; o_ctrg = 0;
        evt_b = 0; evt_c = 0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #4_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        cyc(0, 0, 0, 16'd0, "R1 reset");
        // R4/R5: trigger while disabled clears but does not start
        trig_sw = 1; cyc(0, 1, 0, 16'd0, "R4 trig disabled");
        cmd_en = 1;  cyc(0, 0, 1, 16'd0, "R2 enable");
        cyc(0, 0, 1, 16'd0, "R5 trig ignored while disabled");
        // R4: trigger starts
        trig_sw = 1; cyc(0, 1, 1, 16'd0, "R4 sw trig");
        cyc(1, 0, 1, 16'd1, "R11 first tick");
        cyc(1, 0, 1, 16'd2, "R3 count");
        // R3: no tick, no step
        tick = 0; cyc(0, 0, 1, 16'd2, "R3 no tick"); tick = 1;
        // R4: external trigger wins over tick
        trig_ext = 1; cyc(1, 1, 1, 16'd0, "R4 ext trig");
        cyc(1, 0, 1, 16'd1, "R11 after trig");
        // R8: capture B-stop
        mode_wave = 0; o_bstop = 1; evt_b = 1; cyc(1, 0, 1, 16'd2, "R8 b stop");
        cyc(0, 0, 1, 16'd2, "R8 stopped");
        // R9: B options ignored in waveform
        mode_wave = 1; trig_sync = 1; cyc(0, 1, 1, 16'd0, "R4 sync trig");
        cyc(1, 0, 1, 16'd1, "R4 running");
        o_bstop = 1; o_bdis = 1; evt_b = 1; cyc(1, 0, 1, 16'd2, "R9 b in wave");
        cyc(1, 0, 1, 16'd3, "R9 still running");
        // R10: trigger wins over stop
        o_cstop = 1; evt_c = 1; trig_sw = 1; cyc(1, 1, 1, 16'd0, "R10 trig vs stop");
        cyc(1, 0, 1, 16'd1, "R10 running");
        // R8: waveform C-stop
        o_cstop = 1; evt_c = 1; cyc(1, 0, 1, 16'd2, "R8 c stop");
        cyc(0, 0, 1, 16'd2, "R8 c stopped");
        // R9: C options ignored in capture
        mode_wave = 0; trig_sw = 1; cyc(0, 1, 1, 16'd0, "R4 restart");
        cyc(1, 0, 1, 16'd1, "R4 run");
        o_cdis = 1; o_cstop = 1; o_ctrg = 1; evt_c = 1; cyc(1, 0, 1, 16'd2, "R9 c in capture");
        cyc(1, 0, 1, 16'd3, "R9 c ignored");
        // R6: capture B-disable
        o_bdis = 1; evt_b = 1; cyc(1, 0, 0, 16'd4, "R6 b disable");
        cyc(0, 0, 0, 16'd4, "R6 disabled");
        // R5: stop while disabled has no effect on the run bit
        o_bstop = 1; evt_b = 1; cyc(0, 0, 0, 16'd4, "R5 stop while disabled");
        cmd_en = 1; cyc(0, 0, 1, 16'd4, "R2 re-enable");
        cyc(1, 0, 1, 16'd5, "R5 run kept");
        // R2: disable wins
        cmd_en = 1; cmd_dis = 1; cyc(1, 0, 0, 16'd6, "R2 dis wins");
        cyc(0, 0, 0, 16'd6, "R2 held off");
        cmd_en = 1; cyc(0, 0, 1, 16'd6, "R2 enable");
        cyc(1, 0, 1, 16'd7, "R2 resumed");
        // R7: waveform C-disable
        mode_wave = 1; o_cdis = 1; evt_c = 1; cyc(1, 0, 0, 16'd8, "R7 c disable");
        cmd_en = 1; cyc(0, 0, 1, 16'd8, "R7 re-enable");
        cyc(1, 0, 1, 16'd9, "R7 resumed");
        // R4: compare trigger in waveform
        o_ctrg = 1; evt_c = 1; cyc(1, 1, 1, 16'd0, "R4 c trig");
        cyc(1, 0, 1, 16'd1, "R4 c trig run");
        // R11: wrap
        trig_sw = 1; cyc(1, 1, 1, 16'd0, "R11 wrap start");
        for (int i = 0; i < 65534; i++) @(posedge clk);
        @(negedge clk);
        cyc(1, 0, 1, 16'hFFFF, "R11 top");
        cyc(1, 0, 1, 16'h0000, "R11 wrap");
        #5;
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule